// File: doc/BRIEF.md
# Hysteretic Heater and Cooler Controller

This block is a clocked Moore state machine that decides whether a heater or a cooler should run. Each cycle it compares an unsigned temperature reading with a setpoint and a tolerance. The setpoint and the tolerance are live inputs, so software or a parent block can change them at any time.

The controller starts an actuator when the reading leaves the band formed by the setpoint plus and minus the tolerance. It stops that actuator only when the reading gets back to the setpoint itself. Stopping at the setpoint rather than at the band edge gives hysteresis, which keeps the actuators from chattering near a threshold. The two enables are decoded from the state register alone. A state code is also brought out so that the current mode can be observed.

Top module: `thermo_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in IDLE (state code 2'b00) at the next rising clock edge, with heater_on and cooler_on both low.
- R2: From IDLE, a reading strictly below setpoint minus tolerance moves the machine to HEATING (state code 2'b01) at the next edge. In HEATING, heater_on is 1 and cooler_on is 0.
- R3: From IDLE, a reading strictly above setpoint plus tolerance moves the machine to COOLING (state code 2'b10) at the next edge. In COOLING, cooler_on is 1 and heater_on is 0.
- R4: HEATING is held while the reading is below the setpoint. The machine returns to IDLE at the edge after the reading is at or above the setpoint.
- R5: COOLING is held while the reading is above the setpoint. The machine returns to IDLE at the edge after the reading is at or below the setpoint.
- R6: In IDLE, a reading inside the band, both edges included, keeps the machine in IDLE with both enables low.
- R7: The band edges are computed without wrap-around. When the tolerance exceeds the setpoint, heating never starts. When setpoint plus tolerance exceeds the largest code, cooling never starts.
- R8: heater_on and cooler_on are never high together. A move between HEATING and COOLING always spends at least one cycle in IDLE.
- R9: A change of setpoint or tolerance takes effect in the decision made at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| temp_now | input | TW | Current temperature reading, unsigned |
| temp_goal | input | TW | Setpoint, unsigned |
| temp_tol | input | TW | Tolerance around the setpoint, unsigned |
| heater_on | output | 1 | Heater enable |
| cooler_on | output | 1 | Cooler enable |
| state_code | output | 2 | Current state: 00 IDLE, 01 HEATING, 10 COOLING |

## Verification
The release of one actuator and the start of the other can both be due in the same cycle. This happens when the machine is HEATING and the reading jumps straight above the upper band edge, or when it is COOLING and the reading drops below the lower edge. The bench provokes this with directed jumps to the extreme codes. It also provokes it with random readings held close to the setpoint and a small random tolerance. It then checks, against its own reference model, that the machine spends a cycle in IDLE before the opposite actuator starts, and that the two enables never overlap.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_HEAT = 2'b01,
        MODE_COOL = 2'b10
    } mode_e;

    typedef struct packed {
        logic [1:0] mode;
    } ctrl_regs_t;

endpackage

// File: rtl/thermo_band.sv
module thermo_band #(
    parameter int TW = 8
) (
    input  logic [TW-1:0] temp_now,
    input  logic [TW-1:0] temp_goal,
    input  logic [TW-1:0] temp_tol,
    output logic          below_band,
    output logic          above_band,
    output logic          reached_from_below,
    output logic          reached_from_above
);
    localparam int XW = TW + 1;

    logic [XW-1:0] lo_edge;
    logic [XW-1:0] hi_edge;
    logic          lo_negative;

    always_comb begin
        lo_edge            = {1'b0, temp_goal} - {1'b0, temp_tol};
        hi_edge            = {1'b0, temp_goal} + {1'b0, temp_tol};
        lo_negative        = lo_edge[XW-1];
        below_band         = !lo_negative && ({1'b0, temp_now} < lo_edge);
        above_band         = {1'b0, temp_now} > hi_edge;
        reached_from_below = temp_now >= temp_goal;
        reached_from_above = temp_now <= temp_goal;
    end

endmodule

// File: rtl/thermo_drive.sv
module thermo_drive
    import thermo_pkg::*;
(
    input  logic [1:0] mode,
    output logic       heater_on,
    output logic       cooler_on
);
    always_comb begin
        heater_on = (mode == MODE_HEAT);
        cooler_on = (mode == MODE_COOL);
    end

endmodule

// File: rtl/thermo_ctrl.sv
module thermo_ctrl
    import thermo_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp_now,
    input  logic [TW-1:0] temp_goal,
    input  logic [TW-1:0] temp_tol,
    output logic          heater_on,
    output logic          cooler_on,
    output logic [1:0]    state_code
);
    ctrl_regs_t regs_d;
    ctrl_regs_t regs_q;

    logic below_band;
    logic above_band;
    logic reached_from_below;
    logic reached_from_above;

    thermo_band #(.TW(TW)) band_i (
        .temp_now           (temp_now),
        .temp_goal          (temp_goal),
        .temp_tol           (temp_tol),
        .below_band         (below_band),
        .above_band         (above_band),
        .reached_from_below (reached_from_below),
        .reached_from_above (reached_from_above)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.mode)
            MODE_IDLE: begin
                if (below_band) begin
                    regs_d.mode = MODE_HEAT;
                end else if (above_band) begin
                    regs_d.mode = MODE_COOL;
                end
            end
            MODE_HEAT: begin
                if (reached_from_below) begin
                    regs_d.mode = MODE_IDLE;
                end
            end
            MODE_COOL: begin
                if (reached_from_above) begin
                    regs_d.mode = MODE_IDLE;
                end
            end
            default: regs_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.mode <= MODE_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    thermo_drive drive_i (
        .mode      (regs_q.mode),
        .heater_on (heater_on),
        .cooler_on (cooler_on)
    );

    assign state_code = regs_q.mode;

    // R1: reset lands in IDLE
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (state_code == MODE_IDLE && !heater_on && !cooler_on));

    // R2: a low reading in IDLE starts heating
    p_heat_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state_code == MODE_IDLE && below_band) |=> heater_on);

    // R3: a high reading in IDLE starts cooling
    p_cool_start_r3: assert property (@(posedge clk) disable iff (rst)
        (state_code == MODE_IDLE && !below_band && above_band) |=> cooler_on);

    // R4: heating holds until the setpoint is reached
    p_heat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (heater_on && !reached_from_below) |=> heater_on);

    // R5: cooling holds until the setpoint is reached
    p_cool_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cooler_on && !reached_from_above) |=> cooler_on);

    // R8: enables exclusive, no direct swap between actuators
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(heater_on && cooler_on));
    p_no_swap_r8: assert property (@(posedge clk) disable iff (rst)
        heater_on |=> !cooler_on);

endmodule

// File: tb/thermo_ctrl_tb_top.sv
`timescale 1ns/1ps
module thermo_ctrl_tb_top;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] temp_now = '0;
    logic [TW-1:0] temp_goal = '0;
    logic [TW-1:0] temp_tol = '0;
    logic          heater_on;
    logic          cooler_on;
    logic [1:0]    state_code;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_st   = 0;

    always #2.5 clk = ~clk;

    thermo_ctrl #(.TW(TW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .temp_now   (temp_now),
        .temp_goal  (temp_goal),
        .temp_tol   (temp_tol),
        .heater_on  (heater_on),
        .cooler_on  (cooler_on),
        .state_code (state_code)
    );

    // reference: 0 idle, 1 heating, 2 cooling
    function automatic int model_next(int st, int now, int goal, int tol, bit r);
        int lo;
        int hi;
        lo = goal - tol;
        hi = goal + tol;
        if (r) return 0;
        case (st)
            0: begin
                if (now < lo) return 1;
                if (now > hi) return 2;
                return 0;
            end
            1: return (now >= goal) ? 0 : 1;
            2: return (now <= goal) ? 0 : 2;
            default: return 0;
        endcase
    endfunction

    task automatic compare(string tag);
        logic [1:0] es;
        es = exp_st[1:0];
        n_checks++;
        if (state_code !== es || heater_on !== (exp_st == 1) || cooler_on !== (exp_st == 2)) begin
            n_fails++;
            $display("FAIL %s: state=%0d heat=%0b cool=%0b expected state=%0d heat=%0b cool=%0b",
                     tag, state_code, heater_on, cooler_on, exp_st, exp_st == 1, exp_st == 2);
        end
    endtask

    task automatic step(bit r, int now, int goal, int tol, string tag);
        @(negedge clk);
        rst       = r;
        temp_now  = now[TW-1:0];
        temp_goal = goal[TW-1:0];
        temp_tol  = tol[TW-1:0];
        @(posedge clk);
        exp_st = model_next(exp_st, now, goal, tol, r);
        #1;
        compare(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state, applied while a heat condition is present
        step(1, 10, 70, 2, "R1");
        step(1, 10, 70, 2, "R1");
        // R6 middle and band edges keep IDLE
        step(0, 70, 70, 2, "R6");
        step(0, 68, 70, 2, "R6");
        step(0, 72, 70, 2, "R6");
        // R2 start heating at 60, hold R4, release at setpoint
        step(0, 60, 70, 2, "R2");
        step(0, 69, 70, 2, "R4");
        step(0, 70, 70, 2, "R4");
        // R2 just below the lower edge
        step(0, 67, 70, 2, "R2");
        step(0, 40, 70, 2, "R4");
        // R8 jump straight above upper edge from HEATING: IDLE first, then cool
        step(0, 255, 70, 2, "R8");
        step(0, 255, 70, 2, "R8");
        // R5 cooling hold and release
        step(0, 71, 70, 2, "R5");
        step(0, 70, 70, 2, "R5");
        // R3 start cooling at 80 and just above edge
        step(0, 80, 70, 2, "R3");
        step(0, 0, 70, 2, "R8");
        step(0, 0, 70, 2, "R8");
        step(0, 70, 70, 2, "R4");
        step(0, 73, 70, 2, "R3");
        step(0, 60, 70, 2, "R5");
        // R7 no wrap at either end
        step(0, 0, 1, 5, "R7");
        step(0, 0, 1, 5, "R7");
        step(0, 255, 250, 10, "R7");
        step(0, 255, 255, 255, "R7");
        step(0, 0, 0, 255, "R7");
        // R9 setpoint change takes effect at once
        step(0, 100, 100, 0, "R9");
        step(0, 100, 110, 0, "R9");
        step(0, 100, 100, 0, "R9");
        step(0, 100, 90, 0, "R9");
        step(0, 100, 100, 0, "R9");
        // R1 reset from an active state
        step(0, 50, 100, 0, "R2");
        step(1, 50, 100, 0, "R1");
        // random readings near a random setpoint
        for (int i = 0; i < 4000; i++) begin
            int goal;
            int tol;
            int now;
            bit r;
            goal = int'($urandom_range(255, 0));
            tol  = int'($urandom_range(8, 0));
            now  = goal + int'($urandom_range(24, 0)) - 12;
            if ((i % 97) == 0) now = int'($urandom_range(255, 0));
            if (now < 0) now = 0;
            if (now > 255) now = 255;
            r = ($urandom_range(199, 0) == 0);
            if (r) step(1, now, goal, tol, "R1");
            else if (exp_st == 1) step(0, now, goal, tol, "R4");
            else if (exp_st == 2) step(0, now, goal, tol, "R5");
            else step(0, now, goal, tol, "R6");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule